// File: doc/BRIEF.md
# Dual-Channel Bus-Master Disk Controller Register Bank

This block is the host-visible register bank of a two-channel disk controller that moves data by bus mastering. A 16-byte I/O window is split into one 8-byte slice per channel. Each slice holds a command byte that starts and steers a channel's transfer engine, a status byte that reports activity, errors and completion, and a 32-bit pointer to the transfer descriptor table. The host reaches the window through a simple request/response port that carries 1-, 2- or 4-byte accesses. Each request is answered exactly one cycle later.

The block also turns each channel's drive interrupt level into a pending flag. It ORs the flags into a single interrupt output, which is only driven while a small interrupt-routing register holds a nonzero value. The transfer engines feed activity, error and completion events into the status bytes, and they read the start and direction bits back from the outputs.

Top module: `ide_bm_regs`

## Requirements
- R1: Channel c owns addresses c*8 to c*8+7 (c = req_addr[3]). Its command byte is at offset 0, its status byte at offset 2 and its descriptor pointer at offsets 4 to 7, least significant byte first. Every request gets rsp_valid one cycle later. rsp_rdata is the read data, right-aligned, or zero for a write.
- R2: In the command/status area (offsets 0 to 3) only byte accesses (req_size 0) are honoured. A 2-byte read (req_size 1) returns 0x0000FFFF, and a 4-byte read (req_size 2 or 3) returns 0xFFFFFFFF. Wider writes change nothing.
- R3: Offsets 1 and 3 read as 0xFF, and writes to them change no register.
- R4: A byte write of W to status turns the old value S into (W & 0x60) | (S & 0x01) | (S & ~W & 0x06). Bits 7, 4 and 3 end up zero.
- R5: A byte write to command keeps only bit 0 (start, output cmd_start[c]) and bit 3 (direction, output cmd_dir[c]). All other command bits read as zero.
- R6: Status bit 0 equals the eng_active[c] level of the previous cycle, and the host cannot change it. An eng_err[c] pulse sets bit 1, and an eng_irq[c] pulse sets bit 2. When an engine set and a host clear land in the same cycle, the set wins.
- R7: The descriptor pointer accepts writes of any width at any of its offsets, clipped at offset 7. Its bits 1:0 always read as zero. Reads of any width return the bytes starting at the addressed offset.
- R8: irq_pend[c] equals drv_irq[c] of the previous cycle.
- R9: irq_out is high exactly when some irq_pend bit is high and irq_line is nonzero.
- R10: irq_line resets to 0x0E. A line_we write stores only line_wdata[3:0], and the upper nibble reads as zero.
- R11: After reset the command, status, pointer and pending registers are all zero, and cmd_start, cmd_dir and irq_out are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 4 | Byte address inside the window |
| req_size | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2/3 = 4 bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| line_we | input | 1 | Interrupt-routing register write strobe |
| line_wdata | input | 8 | Interrupt-routing write value |
| irq_line | output | 8 | Interrupt-routing register value |
| drv_irq | input | 2 | Per-channel drive interrupt level |
| eng_active | input | 2 | Per-channel engine busy level |
| eng_err | input | 2 | Per-channel engine error pulse |
| eng_irq | input | 2 | Per-channel engine completion pulse |
| cmd_start | output | 2 | Per-channel start bit |
| cmd_dir | output | 2 | Per-channel direction bit |
| irq_pend | output | 2 | Per-channel pending flag |
| irq_out | output | 1 | Routed combined interrupt |

## Verification
The hardest case to reach is a host write-one-to-clear of status bit 1 that lands in the same cycle as an engine error pulse. The bench drives the error pulse and the write request together at one falling edge, so both meet the same rising edge, and it then expects bit 1 to still be set. A second hard case is the status byte under a mix of engine-set bits and host-loaded bits. The bench first builds that mix with engine pulses and then applies writes whose patterns split the preserved, cleared and loaded fields apart.

// File: rtl/ide_bm_pkg.sv
package ide_bm_pkg;
  localparam int BUS_W   = 32;
  localparam int CH_SPAN = 8;

  typedef enum logic [1:0] {SZ_BYTE = 2'd0, SZ_HALF = 2'd1, SZ_WORD = 2'd2, SZ_WORD2 = 2'd3} acc_size_e;

  // Status byte update for a host byte write
  function automatic logic [7:0] stat_host_merge(input logic [7:0] old_v, input logic [7:0] wd);
    logic [7:0] loaded, kept, survivors;
    loaded    = wd & 8'h60;
    kept      = old_v & 8'h01;
    survivors = old_v & ~wd & 8'h06;
    return loaded | kept | survivors;
  endfunction

  function automatic logic [BUS_W-1:0] width_ones(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 32'h0000_00FF;
      SZ_HALF: return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int size_bytes(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return 1;
      SZ_HALF: return 2;
      default: return 4;
    endcase
  endfunction
endpackage

// File: rtl/ide_bm_chan.sv
module ide_bm_chan
  import ide_bm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel,
  input  logic             wr,
  input  logic [2:0]       off,
  input  logic [1:0]       size,
  input  logic [BUS_W-1:0] wdata,
  input  logic             eng_active,
  input  logic             eng_err,
  input  logic             eng_irq,
  output logic [BUS_W-1:0] rdata,
  output logic [7:0]       cmd_o,
  output logic [7:0]       stat_o
);
  localparam logic [1:0] CMD_OFF  = 2'd0;
  localparam logic [1:0] STAT_OFF = 2'd2;
  localparam int START_BIT = 0;
  localparam int DIR_BIT   = 3;

  logic [7:0]       cmd_q, stat_q, stat_next;
  logic [BUS_W-1:0] ptr_q, ptr_next;

  logic host_wr, in_ctl, byte_acc, cmd_we, stat_we, ptr_we;
  assign host_wr  = sel && wr;
  assign in_ctl   = !off[2];
  assign byte_acc = (size == SZ_BYTE);
  assign cmd_we   = host_wr && in_ctl && byte_acc && (off[1:0] == CMD_OFF);
  assign stat_we  = host_wr && in_ctl && byte_acc && (off[1:0] == STAT_OFF);
  assign ptr_we   = host_wr && off[2];

  always_comb begin
    stat_next = stat_q;
    if (stat_we) stat_next = stat_host_merge(stat_q, wdata[7:0]);
    stat_next[0] = eng_active;
    if (eng_err) stat_next[1] = 1'b1;
    if (eng_irq) stat_next[2] = 1'b1;
  end

  always_comb begin
    int rel;
    ptr_next = ptr_q;
    for (int b = 0; b < 4; b++) begin
      rel = b - int'(off[1:0]);
      if (ptr_we && rel >= 0 && rel < size_bytes(size))
        ptr_next[8*b +: 8] = wdata[8*rel +: 8];
    end
    ptr_next[1:0] = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q  <= '0;
      stat_q <= '0;
      ptr_q  <= '0;
    end else begin
      if (cmd_we) begin
        cmd_q            <= '0;
        cmd_q[START_BIT] <= wdata[START_BIT];
        cmd_q[DIR_BIT]   <= wdata[DIR_BIT];
      end
      stat_q <= stat_next;
      ptr_q  <= ptr_next;
    end
  end

  always_comb begin
    if (in_ctl) begin
      if (!byte_acc) rdata = width_ones(size);
      else begin
        case (off[1:0])
          CMD_OFF:  rdata = {24'b0, cmd_q};
          STAT_OFF: rdata = {24'b0, stat_q};
          default:  rdata = 32'h0000_00FF;
        endcase
      end
    end else begin
      rdata = (ptr_q >> {off[1:0], 3'b000}) & width_ones(size);
    end
  end

  assign cmd_o  = cmd_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/ide_bm_irq.sv
module ide_bm_irq #(
  parameter int NUM_CH = 2,
  parameter logic [7:0] LINE_RST = 8'h0E
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] drv_irq,
  input  logic              line_we,
  input  logic [7:0]        line_wdata,
  output logic [NUM_CH-1:0] pend,
  output logic [7:0]        line,
  output logic              irq_out
);
  localparam logic [7:0] LINE_WMASK = 8'h0F;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= '0;
      line <= LINE_RST;
    end else begin
      pend <= drv_irq;
      if (line_we) line <= line_wdata & LINE_WMASK;
    end
  end

  assign irq_out = (|pend) && (|line);
endmodule

// File: rtl/ide_bm_regs.sv
module ide_bm_regs
  import ide_bm_pkg::*;
#(
  parameter int NUM_CH = 2,
  localparam int ADDR_W = $clog2(NUM_CH * CH_SPAN)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_size,
  input  logic [BUS_W-1:0]  req_wdata,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  input  logic              line_we,
  input  logic [7:0]        line_wdata,
  output logic [7:0]        irq_line,
  input  logic [NUM_CH-1:0] drv_irq,
  input  logic [NUM_CH-1:0] eng_active,
  input  logic [NUM_CH-1:0] eng_err,
  input  logic [NUM_CH-1:0] eng_irq,
  output logic [NUM_CH-1:0] cmd_start,
  output logic [NUM_CH-1:0] cmd_dir,
  output logic [NUM_CH-1:0] irq_pend,
  output logic              irq_out
);
  localparam int CH_W = ADDR_W - 3;

  logic [CH_W-1:0]              ch_idx;
  logic [NUM_CH-1:0][BUS_W-1:0] rd_ch;
  logic [NUM_CH-1:0][7:0]       cmd_v, stat_v;

  assign ch_idx = req_addr[ADDR_W-1:3];

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    ide_bm_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel        (req_valid && (ch_idx == CH_W'(c))),
      .wr         (req_write),
      .off        (req_addr[2:0]),
      .size       (req_size),
      .wdata      (req_wdata),
      .eng_active (eng_active[c]),
      .eng_err    (eng_err[c]),
      .eng_irq    (eng_irq[c]),
      .rdata      (rd_ch[c]),
      .cmd_o      (cmd_v[c]),
      .stat_o     (stat_v[c])
    );
    assign cmd_start[c] = cmd_v[c][0];
    assign cmd_dir[c]   = cmd_v[c][3];
  end

  ide_bm_irq #(.NUM_CH(NUM_CH)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .drv_irq    (drv_irq),
    .line_we    (line_we),
    .line_wdata (line_wdata),
    .pend       (irq_pend),
    .line       (irq_line),
    .irq_out    (irq_out)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_ch[ch_idx] : '0;
    end
  end
endmodule

// File: rtl/ide_bm_regs_chk.sv
module ide_bm_regs_chk #(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_write,
  input logic [ADDR_W-1:0]      req_addr,
  input logic [1:0]             req_size,
  input logic                   rsp_valid,
  input logic [7:0]             irq_line,
  input logic [NUM_CH-1:0]      drv_irq,
  input logic [NUM_CH-1:0]      eng_active,
  input logic [NUM_CH-1:0]      eng_err,
  input logic [NUM_CH-1:0]      eng_irq,
  input logic [NUM_CH-1:0]      irq_pend,
  input logic                   irq_out,
  input logic [NUM_CH-1:0][7:0] cmd_v,
  input logic [NUM_CH-1:0][7:0] stat_v
);
  a_r1_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (rsp_valid == $past(req_valid)));

  a_r8_pend_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_pend == $past(drv_irq)));

  a_r9_irq_route: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == ((|irq_pend) && (irq_line != 8'h00)));

  a_r10_line_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    irq_line[7:4] == 4'h0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    a_r2_wide_cmd_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_size != 2'd0 && !req_addr[2] &&
       req_addr[ADDR_W-1:3] == (ADDR_W-3)'(c)) |=> $stable(cmd_v[c]));

    a_r6_err_sets: assert property (@(posedge clk) disable iff (!rst_n)
      eng_err[c] |=> stat_v[c][1]);

    a_r6_evt_sets: assert property (@(posedge clk) disable iff (!rst_n)
      eng_irq[c] |=> stat_v[c][2]);

    a_r6_active_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stat_v[c][0] == $past(eng_active[c])));
  end
endmodule

bind ide_bm_regs ide_bm_regs_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
  .irq_line(irq_line), .drv_irq(drv_irq), .eng_active(eng_active),
  .eng_err(eng_err), .eng_irq(eng_irq), .irq_pend(irq_pend), .irq_out(irq_out),
  .cmd_v(cmd_v), .stat_v(stat_v)
);

// File: tb/ide_bm_regs_tb.sv
`timescale 1ns/1ps
module ide_bm_regs_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        line_we = 1'b0;
  logic [7:0]  line_wdata = '0;
  logic [7:0]  irq_line;
  logic [1:0]  drv_irq = '0, eng_active = '0, eng_err = '0, eng_irq = '0;
  logic [1:0]  cmd_start, cmd_dir, irq_pend;
  logic        irq_out;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  typedef struct {bit chk; logic [31:0] exp; string tag;} exp_t;
  exp_t sb_q[$];

  always #4 clk = ~clk;

  ide_bm_regs dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [3:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input bit chk, input logic [31:0] exp,
                        input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    e.chk = chk && !wr; e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] wd);
    access(1'b1, a, sz, wd, 1'b0, '0, "");
  endtask

  task automatic rd(input logic [3:0] a, input logic [1:0] sz, input logic [31:0] exp,
                    input string tag);
    access(1'b0, a, sz, '0, 1'b1, exp, tag);
  endtask

  task automatic pulse_err(input int c);
    @(negedge clk); eng_err[c] = 1'b1;
    @(negedge clk); eng_err[c] = 1'b0;
  endtask

  task automatic pulse_evt(input int c);
    @(negedge clk); eng_irq[c] = 1'b1;
    @(negedge clk); eng_irq[c] = 1'b0;
  endtask

  task automatic set_line(input logic [7:0] v);
    @(negedge clk); line_we = 1'b1; line_wdata = v;
    @(negedge clk); line_we = 1'b0;
  endtask

  // Monitor: compare each response against the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb_q.size() == 0) begin
        n_chk++; n_fail++;
        $display("FAIL R1 unexpected response actual=%h expected=none", rsp_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.chk) check(e.tag, rsp_rdata, e.exp);
        else check("R1 write response data", rsp_rdata, 32'h0);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 / R10 reset state
    check("R11 cmd_start", {30'b0, cmd_start}, 32'h0);
    check("R11 irq_out", {31'b0, irq_out}, 32'h0);
    check("R10 line reset", {24'b0, irq_line}, 32'h0E);
    rd(4'h0, 2'd0, 32'h00, "R11 ch0 cmd reset");
    rd(4'h2, 2'd0, 32'h00, "R11 ch0 status reset");
    rd(4'hC, 2'd2, 32'h0,  "R11 ch1 pointer reset");

    // R5 command bits, R1 channel isolation
    wr(4'h0, 2'd0, 32'hFF);
    check("R5 start ch0", {30'b0, cmd_start}, 32'h1);
    check("R5 dir ch0", {30'b0, cmd_dir}, 32'h1);
    rd(4'h0, 2'd0, 32'h09, "R5 cmd readback");
    rd(4'h8, 2'd0, 32'h00, "R1 ch1 cmd untouched");
    wr(4'h8, 2'd0, 32'h08);
    check("R5 dir ch1 only", {30'b0, cmd_dir}, 32'h3);
    check("R5 start ch1 clear", {30'b0, cmd_start}, 32'h1);

    // R4 status write semantics on ch1
    wr(4'hA, 2'd0, 32'h66);
    rd(4'hA, 2'd0, 32'h60, "R4 load bits 5-6 only");
    pulse_err(1);
    pulse_evt(1);
    rd(4'hA, 2'd0, 32'h66, "R6 engine set bits 1-2");
    wr(4'hA, 2'd0, 32'h02);
    rd(4'hA, 2'd0, 32'h04, "R4 W1C bit1, clear 5-6");
    wr(4'hA, 2'd0, 32'hFF);
    rd(4'hA, 2'd0, 32'h60, "R4 all-ones write");

    // R6 active bit and set-over-clear
    @(negedge clk); eng_active[0] = 1'b1;
    rd(4'h2, 2'd0, 32'h01, "R6 active set");
    wr(4'h2, 2'd0, 32'h00);
    rd(4'h2, 2'd0, 32'h01, "R6 active not host writable");
    @(negedge clk); eng_active[0] = 1'b0;
    rd(4'h2, 2'd0, 32'h00, "R6 active cleared");
    pulse_err(0);
    @(negedge clk);
    eng_err[0] = 1'b1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h2; req_size = 2'd0; req_wdata = 32'h02;
    begin exp_t e; e.chk = 1'b0; e.exp = '0; e.tag = ""; sb_q.push_back(e); end
    @(negedge clk);
    eng_err[0] = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    rd(4'h2, 2'd0, 32'h02, "R6 set wins over W1C");

    // R2 wide access in command/status area
    rd(4'h0, 2'd1, 32'h0000FFFF, "R2 half read ones");
    rd(4'h8, 2'd2, 32'hFFFFFFFF, "R2 word read ones");
    wr(4'h0, 2'd1, 32'h0);
    rd(4'h0, 2'd0, 32'h09, "R2 half write ignored");
    wr(4'h2, 2'd2, 32'hFFFF_FFFF);
    rd(4'h2, 2'd0, 32'h02, "R2 word write to status ignored");

    // R3 unused offsets
    rd(4'h1, 2'd0, 32'hFF, "R3 offset1");
    rd(4'hB, 2'd0, 32'hFF, "R3 offset3");
    wr(4'h1, 2'd0, 32'h00);
    wr(4'h3, 2'd0, 32'hFF);
    rd(4'h0, 2'd0, 32'h09, "R3 cmd unchanged");
    rd(4'h2, 2'd0, 32'h02, "R3 status unchanged");

    // R7 descriptor pointer
    wr(4'h4, 2'd2, 32'h12345677);
    rd(4'h4, 2'd2, 32'h12345674, "R7 word write aligned");
    rd(4'h5, 2'd0, 32'h56, "R7 byte read offset5");
    rd(4'h6, 2'd1, 32'h1234, "R7 half read offset6");
    wr(4'h4, 2'd0, 32'hFF);
    rd(4'h4, 2'd2, 32'h123456FC, "R7 byte write low bits forced");
    wr(4'hF, 2'd0, 32'hAB);
    rd(4'hC, 2'd2, 32'hAB000000, "R7 ch1 top byte");
    wr(4'hE, 2'd2, 32'hCCDD_EEFF);
    rd(4'hC, 2'd2, 32'hEEFF0000, "R7 clipped write");

    // R8 / R9 / R10 interrupt path
    @(negedge clk); drv_irq = 2'b10;
    @(negedge clk);
    check("R8 pend ch1", {30'b0, irq_pend}, 32'h2);
    check("R9 irq out routed", {31'b0, irq_out}, 32'h1);
    set_line(8'hF0);
    check("R10 upper nibble dropped", {24'b0, irq_line}, 32'h00);
    check("R9 zero line blocks irq", {31'b0, irq_out}, 32'h0);
    set_line(8'hA5);
    check("R10 low nibble stored", {24'b0, irq_line}, 32'h05);
    check("R9 irq restored", {31'b0, irq_out}, 32'h1);
    @(negedge clk); drv_irq = 2'b01;
    @(negedge clk);
    check("R8 pend ch0", {30'b0, irq_pend}, 32'h1);
    check("R9 irq from ch0", {31'b0, irq_out}, 32'h1);
    @(negedge clk); drv_irq = 2'b00;
    @(negedge clk);
    check("R8 pend cleared", {30'b0, irq_pend}, 32'h0);
    check("R9 irq cleared", {31'b0, irq_out}, 32'h0);

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R1 missing responses actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule